// File: doc/BRIEF.md
# Unaligned Word Load Sequencer

This block sits between a load unit and a byte-addressable data memory port that only serves naturally aligned byte, halfword and word reads. It accepts a 32-bit word load at any byte address. It then walks a fixed sequence of aligned sub-reads, chosen by the two low address bits, and merges the returned pieces into one big-endian word.

The memory port has a single-cycle synchronous read: data for a read issued in one cycle is present on `mem_rdata_i` in the next cycle. The sequencer issues one sub-read per cycle, so each read's data is merged while the following read goes out. When all pieces are in, the block presents the word with a one-cycle response pulse. The block never faults on a misaligned address and never performs a wide read followed by a rotate.

Top module: `uls_seq`

## Requirements
- R1: While `rst_ni` is low and after it rises, `req_ready_o` is 1, `resp_valid_o` is 0, `mem_rd_o` is 0 and `resp_data_o` is 0.
- R2: `req_ready_o` is 1 only while the sequencer is idle. A `req_valid_i` seen while it is busy is ignored: it changes neither the sub-reads nor the result, and it produces no extra response.
- R3: For address bits [1:0] = 00, exactly one word read (`mem_size_o` = 2) is issued at the request address, and the result equals the returned word.
- R4: For address bits [1:0] = 10, two halfword reads (`mem_size_o` = 1) are issued, first at A and then at A+2. The first fills result bits [31:16] and the second fills bits [15:0].
- R5: For odd address bits [1:0] (01 or 11), three reads are issued in this order: a byte (`mem_size_o` = 0) at A, a halfword at A+1, and a byte at A+3. These fill result bits [31:24], [23:8] and [7:0], and the pieces are ORed together.
- R6: The result is big-endian: the byte at address A+i lands in result bits [31-8i:24-8i]. Addresses wrap modulo 2^32.
- R7: Every sub-read is naturally aligned: halfword addresses are even and word addresses are multiples of four.
- R8: Each sub-read is zero-extended. Bits of `mem_rdata_i` above the requested size (above bit 7 for a byte, above bit 15 for a halfword) have no effect on the result.
- R9: With k sub-reads, `mem_rd_o` is high for k consecutive cycles starting the cycle after acceptance. `resp_valid_o` is a one-cycle pulse in the second cycle after the last `mem_rd_o` cycle, that is, the cycle after the last data is captured. `req_ready_o` returns to 1 in the cycle after the pulse.
- R10: Asserting `rst_ni` low during a sequence returns the block to idle at once and clears the partial result, so `resp_data_o` reads 0 and no response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Load request valid |
| req_addr_i | input | 32 | Byte address of the word to load |
| req_ready_o | output | 1 | High when idle and able to accept a request |
| mem_rd_o | output | 1 | Sub-read strobe to memory |
| mem_addr_o | output | 32 | Aligned sub-read address |
| mem_size_o | output | 2 | Sub-read size: 0 byte, 1 halfword, 2 word |
| mem_rdata_i | input | 32 | Read data, valid the cycle after `mem_rd_o`, right-justified |
| resp_valid_o | output | 1 | One-cycle result pulse |
| resp_data_o | output | 32 | Merged big-endian word |

## Verification
A wrong step counter or offset decode shows up on the memory side in the first or second cycle after acceptance, as a wrong size or address, or a read that breaks alignment. A mis-set shift or a stale accumulator shows up only at the response pulse, as bytes swapped or ORed over each other. A lost pending flag shows up as a missing byte or a shifted response cycle. The sweep covers every offset over many bases, including bases whose sub-reads wrap past the top of the address space. It returns junk in the unused upper data bits and drives noise on the request port while the block is busy, so masking and request gating are each seen within one sequence.

// File: rtl/uls_pkg.sv
package uls_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DRAIN, ST_RESP} state_e;
  typedef struct packed {
    size_e      size;
    logic [1:0] addr_inc;
    logic [4:0] shift;
    logic       last;
  } step_t;
endpackage

// File: rtl/uls_plan.sv
module uls_plan
  import uls_pkg::*;
(
  input  logic [1:0] off_i,
  input  logic [1:0] step_i,
  output step_t      step_o
);
  always_comb begin
    step_o = '{size: SZ_WORD, addr_inc: 2'd0, shift: 5'd0, last: 1'b1};
    if (off_i[0]) begin
      // odd: byte, half, byte
      unique case (step_i)
        2'd0:    step_o = '{size: SZ_BYTE, addr_inc: 2'd0, shift: 5'd24, last: 1'b0};
        2'd1:    step_o = '{size: SZ_HALF, addr_inc: 2'd1, shift: 5'd8,  last: 1'b0};
        default: step_o = '{size: SZ_BYTE, addr_inc: 2'd3, shift: 5'd0,  last: 1'b1};
      endcase
    end else if (off_i[1]) begin
      if (step_i == 2'd0) step_o = '{size: SZ_HALF, addr_inc: 2'd0, shift: 5'd16, last: 1'b0};
      else                step_o = '{size: SZ_HALF, addr_inc: 2'd2, shift: 5'd0,  last: 1'b1};
    end
  end
endmodule

// File: rtl/uls_merge.sv
module uls_merge
  import uls_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cap_i,
  input  size_e         size_i,
  input  logic [4:0]    shift_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] acc_o
);
  logic [DW-1:0] mask, piece, acc_q;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: mask = DW'(8'hff);
      SZ_HALF: mask = DW'(16'hffff);
      default: mask = '1;
    endcase
    piece = (rdata_i & mask) << shift_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (cap_i)  acc_q <= acc_q | piece;
  end

  assign acc_o = acc_q;

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !clr_i) |-> ((acc_q & (mask << shift_i)) == '0)); // R6
  AST_CLR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_o == '0)); // R10
endmodule

// File: rtl/uls_seq.sv
module uls_seq
  import uls_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          req_ready_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          resp_valid_o,
  output logic [31:0]   resp_data_o
);
  localparam int DW = 32;

  state_e        state_q;
  logic [1:0]    step_q;
  logic [AW-1:0] base_q;
  logic          pend_q;
  size_e         pend_size_q;
  logic [4:0]    pend_shift_q;
  step_t         cur;
  logic          accept;

  uls_plan u_plan (
    .off_i (base_q[1:0]),
    .step_i(step_q),
    .step_o(cur)
  );

  assign accept = (state_q == ST_IDLE) && req_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      step_q       <= '0;
      base_q       <= '0;
      pend_q       <= 1'b0;
      pend_size_q  <= SZ_WORD;
      pend_shift_q <= '0;
    end else begin
      pend_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          base_q  <= req_addr_i;
          step_q  <= '0;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          pend_q       <= 1'b1;
          pend_size_q  <= cur.size;
          pend_shift_q <= cur.shift;
          if (cur.last) state_q <= ST_DRAIN;
          else          step_q  <= step_q + 2'd1;
        end
        ST_DRAIN: state_q <= ST_RESP;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  uls_merge #(.DW(DW)) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .cap_i  (pend_q),
    .size_i (pend_size_q),
    .shift_i(pend_shift_q),
    .rdata_i(mem_rdata_i),
    .acc_o  (resp_data_o)
  );

  assign req_ready_o  = (state_q == ST_IDLE);
  assign mem_rd_o     = (state_q == ST_ISSUE);
  assign mem_addr_o   = base_q + AW'(cur.addr_inc);
  assign mem_size_o   = cur.size;
  assign resp_valid_o = (state_q == ST_RESP);

  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_rd_o && !resp_valid_o)); // R2
  AST_ACCEPT_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (mem_rd_o && mem_addr_o == $past(req_addr_i))); // R9
  AST_RESP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> (!resp_valid_o && req_ready_o)); // R9
  AST_SUB_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> ((mem_size_o == SZ_BYTE) ||
                  (mem_size_o == SZ_HALF && !mem_addr_o[0]) ||
                  (mem_size_o == SZ_WORD && mem_addr_o[1:0] == 2'b00))); // R7
  AST_RESP_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(pend_q)); // R9
endmodule

// File: tb/uls_seq_tb.sv
`timescale 1ns/1ps
module uls_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, mem_rd, resp_valid;
  logic [31:0] mem_addr, resp_data;
  logic [1:0]  mem_size;
  logic [31:0] mem_rdata = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uls_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_rdata_i(mem_rdata), .resp_valid_o(resp_valid),
    .resp_data_o(resp_data)
  );

  function automatic logic [7:0] mb(input logic [31:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ a[31:24] ^ 8'h5a;
  endfunction

  // memory model: junk in unused upper bits (R8)
  always @(posedge clk)
    if (mem_rd) begin
      case (mem_size)
        2'd0:    mem_rdata <= {24'hc3a5f0, mb(mem_addr)};
        2'd1:    mem_rdata <= {16'h9e37, mb(mem_addr), mb(mem_addr + 32'd1)};
        default: mem_rdata <= {mb(mem_addr), mb(mem_addr + 32'd1),
                               mb(mem_addr + 32'd2), mb(mem_addr + 32'd3)};
      endcase
    end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int nsub(input logic [1:0] off);
    return off[0] ? 3 : (off[1] ? 2 : 1);
  endfunction

  function automatic logic [1:0] esz(input logic [1:0] off, input int s);
    if (off[0]) return (s == 1) ? 2'd1 : 2'd0;
    if (off[1]) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [31:0] einc(input logic [1:0] off, input int s);
    if (off[0]) return (s == 0) ? 32'd0 : ((s == 1) ? 32'd1 : 32'd3);
    if (off[1]) return (s == 0) ? 32'd0 : 32'd2;
    return 32'd0;
  endfunction

  task automatic run_req(input logic [31:0] a, input bit noisy);
    int n;
    string tag;
    logic [31:0] exp;
    n = nsub(a[1:0]);
    tag = a[0] ? "R5" : (a[1] ? "R4" : "R3");
    exp = {mb(a), mb(a + 32'd1), mb(a + 32'd2), mb(a + 32'd3)}; // R6 big-endian
    @(negedge clk);
    chk(req_ready === 1'b1, "R2 ready idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_addr  = a;
    for (int c = 1; c <= n + 3; c++) begin
      @(negedge clk);
      if (c == 1) begin
        req_valid = noisy;
        req_addr  = ~a;
      end
      if (c <= n) begin
        chk(mem_rd === 1'b1, "R9 rd burst", {31'd0, mem_rd}, 32'd1);
        chk(mem_size === esz(a[1:0], c - 1), {tag, " size"}, {30'd0, mem_size},
            {30'd0, esz(a[1:0], c - 1)});
        chk(mem_addr === a + einc(a[1:0], c - 1), {tag, " addr"}, mem_addr,
            a + einc(a[1:0], c - 1));
        chk((mem_size != 2'd1 || !mem_addr[0]) && (mem_size != 2'd2 || mem_addr[1:0] == 2'b00),
            "R7 aligned", mem_addr, a + einc(a[1:0], c - 1));
      end else begin
        chk(mem_rd === 1'b0, "R9 rd stop", {31'd0, mem_rd}, 32'd0);
      end
      chk(resp_valid === (c == n + 2), "R9 resp cycle", {31'd0, resp_valid},
          {31'd0, c == n + 2});
      chk(req_ready === (c == n + 3), "R2 ready busy", {31'd0, req_ready}, {31'd0, c == n + 3});
      if (c == n + 2) begin
        chk(resp_data === exp, {tag, " R6 R8 data"}, resp_data, exp);
        req_valid = 1'b0;
      end
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [8];
    bases = '{32'h0000_0000, 32'h0000_1000, 32'h1234_5670, 32'h8000_0008,
              32'hdead_bee0, 32'h7fff_fff8, 32'hffff_fff8, 32'hffff_fffc};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1 && resp_valid === 1'b0 && mem_rd === 1'b0,
        "R1 in reset", {29'd0, req_ready, resp_valid, mem_rd}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && resp_valid === 1'b0 && mem_rd === 1'b0,
        "R1 after reset", {29'd0, req_ready, resp_valid, mem_rd}, 32'd4);
    chk(resp_data === 32'd0, "R1 data", resp_data, 32'd0);
    foreach (bases[i])
      for (int o = 0; o < 8; o++)
        run_req(bases[i] + 32'(o), (o % 2) == 1);
    // R10 reset in the middle of an odd sequence
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_2003;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(req_ready === 1'b1 && mem_rd === 1'b0 && resp_valid === 1'b0, "R10 idle",
        {29'd0, req_ready, resp_valid, mem_rd}, 32'd4);
    chk(resp_data === 32'd0, "R10 cleared", resp_data, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(resp_valid === 1'b0, "R10 no resp", {31'd0, resp_valid}, 32'd0);
    end
    run_req(32'h0000_2001, 1'b0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule